// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block converts a segment:offset operand reference into a physical memory address. The offset is assembled from an optional base register (BX or BP), an optional index register (SI or DI) and an optional displacement. The displacement is either a short 8-bit field or a full 16-bit word. A segment register is then chosen. That is the implied segment for the addressing form, unless an explicit override code names another one. The segment value is shifted left by four bit positions and added to the offset.

Only the low 16 bits of each general register are presented to the block. The caller pulses `in_valid` together with a complete reference. One clock later the block shows either a legal address with `out_valid` or a rejected encoding with `out_err`. Aliases, meaning different segment:offset pairs that reach the same physical byte, are accepted without comment.

Top module: `seg_addr_gen`

## Requirements
- R1: On a legal request, `phys_addr` equals (segment × 16 + offset) modulo 2^20, so a carry out of bit 19 is dropped (FFFFH:0010H gives 00000H).
- R2: The offset is (base + index + displacement) modulo 2^16; absent parts count as zero. Base codes are 0 none, 1 BX, 2 BP. Index codes are 0 none, 1 SI, 2 DI.
- R3: Displacement code 1 takes `disp[7:0]` sign-extended to 16 bits. Code 2 takes all 16 bits of `disp`. Code 0 adds nothing.
- R4: With no override, the segment is SS when the base code is BP, and DS for every other legal form, including direct, index-only and BX-based forms.
- R5: When `ovr_en` is 1, `ovr_seg` picks the segment and replaces the implied one. The codes are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS.
- R6: A request raises `out_err` and keeps `out_valid` low in any of these cases: base code 3, index code 3, displacement code 3, all three parts absent, or an enabled override with code 6 or 7.
- R7: `out_valid` or `out_err` is high for exactly the one cycle after an accepted `in_valid`, and never otherwise. The two flags are never high together.
- R8: A synchronous active-high `rst` sets `phys_addr` to 0 and clears `out_valid` and `out_err` at the next clock edge.
- R9: `phys_addr` holds its previous value after an idle cycle and after a rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| seg_es | input | 16 | Extra segment value |
| seg_fs | input | 16 | Second extra segment value |
| seg_gs | input | 16 | Third extra segment value |
| reg_bx | input | 16 | Low half of the BX-type base register |
| reg_bp | input | 16 | Low half of the BP-type base register |
| reg_si | input | 16 | Low half of the SI-type index register |
| reg_di | input | 16 | Low half of the DI-type index register |
| base_sel | input | 2 | Base choice: 0 none, 1 BX, 2 BP, 3 illegal |
| index_sel | input | 2 | Index choice: 0 none, 1 SI, 2 DI, 3 illegal |
| disp_sel | input | 2 | Displacement: 0 none, 1 short, 2 word, 3 illegal |
| disp | input | 16 | Displacement field |
| ovr_en | input | 1 | Segment override enable |
| ovr_seg | input | 3 | Override code: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| phys_addr | output | 20 | Registered physical address |
| out_valid | output | 1 | Address in `phys_addr` is new and legal |
| out_err | output | 1 | Last request had an illegal encoding |

## Verification
A wrong internal choice shows up one cycle after the strobe, as a wrong `phys_addr` value. Choosing the wrong implied segment moves the address by the difference of two segment bases. A missing wrap appears only near FFFFH offsets or near the top of the 1 MB space, so those edges are driven on purpose. A bad legality decode shows up on the same cycle as a wrong flag pair, and a rejected request also shows whether `phys_addr` held its previous value. Random legal and illegal mixes against a bench model cover the override codes and displacement widths between those directed edges.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   typedef enum logic [1:0] {
      BASE_NONE = 2'd0,
      BASE_BX   = 2'd1,
      BASE_BP   = 2'd2,
      BASE_BAD  = 2'd3
   } base_sel_e;

   typedef enum logic [1:0] {
      IDX_NONE = 2'd0,
      IDX_SI   = 2'd1,
      IDX_DI   = 2'd2,
      IDX_BAD  = 2'd3
   } index_sel_e;

   typedef enum logic [1:0] {
      DSP_NONE  = 2'd0,
      DSP_SHORT = 2'd1,
      DSP_WORD  = 2'd2,
      DSP_BAD   = 2'd3
   } disp_sel_e;

   typedef enum logic [2:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_code_e;

   localparam int unsigned SEG_COUNT = 6;

endpackage

// File: rtl/seg_ea_unit.sv
module seg_ea_unit
   import seg_addr_pkg::*;
#(
   parameter int unsigned OFS_W    = 16,
   parameter int unsigned SHORT_W  = 8,
   parameter bit          SIGN_EXT = 1'b1
) (
   input  logic [1:0]       base_sel,
   input  logic [1:0]       index_sel,
   input  logic [1:0]       disp_sel,
   input  logic [OFS_W-1:0] reg_bx,
   input  logic [OFS_W-1:0] reg_bp,
   input  logic [OFS_W-1:0] reg_si,
   input  logic [OFS_W-1:0] reg_di,
   input  logic [OFS_W-1:0] disp,
   output logic [OFS_W-1:0] ofs,
   output logic             uses_bp,
   output logic             ea_err
);

   localparam int unsigned EXT_W = OFS_W - SHORT_W;

   if (SHORT_W == 0 || SHORT_W >= OFS_W) begin : g_bad_short
      $error("seg_ea_unit: SHORT_W must lie between 1 and OFS_W-1");
   end

   base_sel_e  base_e;
   index_sel_e idx_e;
   disp_sel_e  dsp_e;

   logic [OFS_W-1:0] base_term;
   logic [OFS_W-1:0] idx_term;
   logic [OFS_W-1:0] dsp_term;
   logic [OFS_W-1:0] short_ext;

   assign base_e = base_sel_e'(base_sel);
   assign idx_e  = index_sel_e'(index_sel);
   assign dsp_e  = disp_sel_e'(disp_sel);

   if (SIGN_EXT) begin : g_short_signed
      assign short_ext = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
   end else begin : g_short_unsigned
      assign short_ext = {{EXT_W{1'b0}}, disp[SHORT_W-1:0]};
   end

   always_comb begin
      unique case (base_e)
         BASE_BX: base_term = reg_bx;
         BASE_BP: base_term = reg_bp;
         default: base_term = '0;
      endcase
      unique case (idx_e)
         IDX_SI:  idx_term = reg_si;
         IDX_DI:  idx_term = reg_di;
         default: idx_term = '0;
      endcase
      unique case (dsp_e)
         DSP_SHORT: dsp_term = short_ext;
         DSP_WORD:  dsp_term = disp;
         default:   dsp_term = '0;
      endcase
   end

   // three-way sum truncated to the offset width: wraps modulo 2^OFS_W
   assign ofs     = base_term + idx_term + dsp_term;
   assign uses_bp = (base_e == BASE_BP);
   assign ea_err  = (base_e == BASE_BAD) || (idx_e == IDX_BAD) || (dsp_e == DSP_BAD)
                 || ((base_e == BASE_NONE) && (idx_e == IDX_NONE) && (dsp_e == DSP_NONE));

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic [SEG_W-1:0] seg_cs,
   input  logic [SEG_W-1:0] seg_ss,
   input  logic [SEG_W-1:0] seg_ds,
   input  logic [SEG_W-1:0] seg_es,
   input  logic [SEG_W-1:0] seg_fs,
   input  logic [SEG_W-1:0] seg_gs,
   input  logic             uses_bp,
   input  logic             ovr_en,
   input  logic [2:0]       ovr_seg,
   output logic [SEG_W-1:0] seg_val,
   output logic             seg_err
);

   logic [SEG_W-1:0] seg_bank [SEG_COUNT];
   logic [2:0]       pick;

   assign seg_bank[SEG_ES] = seg_es;
   assign seg_bank[SEG_CS] = seg_cs;
   assign seg_bank[SEG_SS] = seg_ss;
   assign seg_bank[SEG_DS] = seg_ds;
   assign seg_bank[SEG_FS] = seg_fs;
   assign seg_bank[SEG_GS] = seg_gs;

   always_comb begin
      if (ovr_en)       pick = ovr_seg;
      else if (uses_bp) pick = SEG_SS;
      else              pick = SEG_DS;
   end

   assign seg_err = ovr_en && (int'(ovr_seg) >= SEG_COUNT);
   assign seg_val = seg_err ? '0 : seg_bank[pick];

   always_comb begin
      if (!ovr_en) begin
         a_implied_code_r4 : assert (pick == SEG_SS || pick == SEG_DS);
      end
   end

endmodule

// File: rtl/seg_phys_adder.sv
module seg_phys_adder #(
   parameter int unsigned SEG_W = 16,
   parameter int unsigned OFS_W = 16,
   parameter int unsigned SHIFT = 4,
   parameter int unsigned PA_W  = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0] seg_val,
   input  logic [OFS_W-1:0] ofs,
   output logic [PA_W-1:0]  pa
);

   if (PA_W != SEG_W + SHIFT) begin : g_bad_pa
      $error("seg_phys_adder: PA_W must equal SEG_W + SHIFT");
   end
   if (OFS_W >= PA_W) begin : g_bad_ofs
      $error("seg_phys_adder: offset must be narrower than the address");
   end

   logic [PA_W-1:0] seg_base;
   logic [PA_W-1:0] ofs_ext;

   if (SHIFT == 0) begin : g_no_shift
      assign seg_base = seg_val;
   end else begin : g_shift
      assign seg_base = {seg_val, {SHIFT{1'b0}}};
   end

   assign ofs_ext = {{(PA_W-OFS_W){1'b0}}, ofs};
   // carry out of the top bit is discarded
   assign pa      = seg_base + ofs_ext;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W          = 16,
   parameter int unsigned OFS_W          = 16,
   parameter int unsigned SEG_SHIFT      = 4,
   parameter int unsigned SHORT_W        = 8,
   parameter bit          SIGN_EXT_SHORT = 1'b1,
   localparam int unsigned PA_W          = SEG_W + SEG_SHIFT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [SEG_W-1:0] seg_cs,
   input  logic [SEG_W-1:0] seg_ss,
   input  logic [SEG_W-1:0] seg_ds,
   input  logic [SEG_W-1:0] seg_es,
   input  logic [SEG_W-1:0] seg_fs,
   input  logic [SEG_W-1:0] seg_gs,
   input  logic [OFS_W-1:0] reg_bx,
   input  logic [OFS_W-1:0] reg_bp,
   input  logic [OFS_W-1:0] reg_si,
   input  logic [OFS_W-1:0] reg_di,
   input  logic [1:0]       base_sel,
   input  logic [1:0]       index_sel,
   input  logic [1:0]       disp_sel,
   input  logic [OFS_W-1:0] disp,
   input  logic             ovr_en,
   input  logic [2:0]       ovr_seg,
   output logic [PA_W-1:0]  phys_addr,
   output logic             out_valid,
   output logic             out_err
);

   logic [OFS_W-1:0] ofs;
   logic             uses_bp;
   logic             ea_err;
   logic [SEG_W-1:0] seg_val;
   logic             seg_err;
   logic [PA_W-1:0]  pa_next;
   logic             req_err;

   seg_ea_unit #(
      .OFS_W   (OFS_W),
      .SHORT_W (SHORT_W),
      .SIGN_EXT(SIGN_EXT_SHORT)
   ) u_ea (
      .base_sel (base_sel),
      .index_sel(index_sel),
      .disp_sel (disp_sel),
      .reg_bx   (reg_bx),
      .reg_bp   (reg_bp),
      .reg_si   (reg_si),
      .reg_di   (reg_di),
      .disp     (disp),
      .ofs      (ofs),
      .uses_bp  (uses_bp),
      .ea_err   (ea_err)
   );

   seg_select #(
      .SEG_W(SEG_W)
   ) u_seg (
      .seg_cs (seg_cs),
      .seg_ss (seg_ss),
      .seg_ds (seg_ds),
      .seg_es (seg_es),
      .seg_fs (seg_fs),
      .seg_gs (seg_gs),
      .uses_bp(uses_bp),
      .ovr_en (ovr_en),
      .ovr_seg(ovr_seg),
      .seg_val(seg_val),
      .seg_err(seg_err)
   );

   seg_phys_adder #(
      .SEG_W(SEG_W),
      .OFS_W(OFS_W),
      .SHIFT(SEG_SHIFT),
      .PA_W (PA_W)
   ) u_pa (
      .seg_val(seg_val),
      .ofs    (ofs),
      .pa     (pa_next)
   );

   assign req_err = ea_err || seg_err;

   always_ff @(posedge clk) begin
      if (rst) begin
         phys_addr <= '0;
         out_valid <= 1'b0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= in_valid && !req_err;
         out_err   <= in_valid && req_err;
         if (in_valid && !req_err) begin
            phys_addr <= pa_next;
         end
      end
   end

   p_flags_exclusive_r7 : assert property (@(posedge clk) disable iff (rst)
      !(out_valid && out_err));

   p_flag_needs_strobe_r7 : assert property (@(posedge clk) disable iff (rst)
      (out_valid || out_err) |-> $past(in_valid));

   p_hold_when_idle_r9 : assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> $stable(phys_addr));

   p_reset_clears_r8 : assert property (@(posedge clk)
      rst |=> (phys_addr == '0 && !out_valid && !out_err));

   p_err_from_encoding_r6 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && base_sel == 2'd3) |=> out_err);

endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [15:0] seg_cs, seg_ss, seg_ds, seg_es, seg_fs, seg_gs;
   logic [15:0] reg_bx, reg_bp, reg_si, reg_di;
   logic [1:0]  base_sel, index_sel, disp_sel;
   logic [15:0] disp;
   logic        ovr_en;
   logic [2:0]  ovr_seg;
   logic [19:0] phys_addr;
   logic        out_valid;
   logic        out_err;

   int n_checks = 0;
   int n_fail   = 0;
   logic [19:0] last_pa;

   always #2 clk = ~clk;

   seg_addr_gen uut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
      .seg_es(seg_es), .seg_fs(seg_fs), .seg_gs(seg_gs),
      .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
      .base_sel(base_sel), .index_sel(index_sel), .disp_sel(disp_sel),
      .disp(disp), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
      .phys_addr(phys_addr), .out_valid(out_valid), .out_err(out_err)
   );

   function automatic logic model_err();
      if (base_sel == 2'd3 || index_sel == 2'd3 || disp_sel == 2'd3) return 1'b1;
      if (base_sel == 2'd0 && index_sel == 2'd0 && disp_sel == 2'd0) return 1'b1;
      if (ovr_en && ovr_seg > 3'd5) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [15:0] model_ofs();
      logic [15:0] s = 16'h0;
      if (base_sel == 2'd1) s = s + reg_bx;
      if (base_sel == 2'd2) s = s + reg_bp;
      if (index_sel == 2'd1) s = s + reg_si;
      if (index_sel == 2'd2) s = s + reg_di;
      if (disp_sel == 2'd1) s = s + {{8{disp[7]}}, disp[7:0]};
      if (disp_sel == 2'd2) s = s + disp;
      return s;
   endfunction

   function automatic logic [15:0] model_seg();
      if (ovr_en) begin
         case (ovr_seg)
            3'd0: return seg_es;
            3'd1: return seg_cs;
            3'd2: return seg_ss;
            3'd3: return seg_ds;
            3'd4: return seg_fs;
            default: return seg_gs;
         endcase
      end
      return (base_sel == 2'd2) ? seg_ss : seg_ds;
   endfunction

   function automatic logic [19:0] model_pa();
      logic [19:0] b = {model_seg(), 4'h0};
      return b + {4'h0, model_ofs()};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      in_valid = 0; ovr_en = 0; ovr_seg = 0;
      base_sel = 0; index_sel = 0; disp_sel = 0; disp = 0;
   endtask

   // drive at negedge, result visible after next posedge, sampled at following negedge
   task automatic issue(input string req);
      logic        e;
      logic [19:0] p;
      e = model_err();
      p = model_pa();
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, {31'd0, out_valid}, {31'd0, !e});
      check({req, " err"},   {31'd0, out_err},   {31'd0, e});
      if (!e) last_pa = p;
      check({req, " addr"},  {12'd0, phys_addr}, {12'd0, last_pa});
   endtask

   task automatic set_op(input logic [1:0] b, input logic [1:0] x,
                         input logic [1:0] d, input logic [15:0] dv);
      base_sel = b; index_sel = x; disp_sel = d; disp = dv; ovr_en = 0;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      idle_inputs();
      seg_cs = 16'h1000; seg_ss = 16'h2000; seg_ds = 16'h3000;
      seg_es = 16'h4000; seg_fs = 16'h5000; seg_gs = 16'h6000;
      reg_bx = 0; reg_bp = 0; reg_si = 0; reg_di = 0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 addr",  {12'd0, phys_addr}, 32'd0);
      check("R8 valid", {31'd0, out_valid}, 32'd0);
      check("R8 err",   {31'd0, out_err},   32'd0);
      rst = 1'b0;
      last_pa = 20'h0;

      // R1 direct: 1234H:0022H -> 12362H
      seg_ds = 16'h1234; set_op(2'd0, 2'd0, 2'd2, 16'h0022);
      issue("R1 direct");
      check("R1 ref value", {12'd0, phys_addr}, 32'h12362);

      // R2 BX+DI+0400 with DS=0B00 -> 0B900
      seg_ds = 16'h0B00; reg_bx = 16'h0300; reg_di = 16'h0200;
      set_op(2'd1, 2'd2, 2'd2, 16'h0400);
      issue("R2 bx+di+disp");
      check("R2 ref value", {12'd0, phys_addr}, 32'h0B900);

      // R1 aliases 002BH:0013H and 002CH:0003H both 002C3H
      seg_ds = 16'h002B; set_op(2'd0, 2'd0, 2'd2, 16'h0013); issue("R1 alias a");
      check("R1 alias a value", {12'd0, phys_addr}, 32'h002C3);
      seg_ds = 16'h002C; set_op(2'd0, 2'd0, 2'd2, 16'h0003); issue("R1 alias b");
      check("R1 alias b value", {12'd0, phys_addr}, 32'h002C3);

      // R1 20-bit wrap: FFFFH:0010H -> 00000H
      seg_ds = 16'hFFFF; set_op(2'd0, 2'd0, 2'd2, 16'h0010); issue("R1 wrap20");
      check("R1 wrap20 value", {12'd0, phys_addr}, 32'h00000);

      // R2 offset wrap: SI=FFFF + disp 0002 -> offset 0001
      seg_ds = 16'h3000; reg_si = 16'hFFFF; set_op(2'd0, 2'd1, 2'd2, 16'h0002);
      issue("R2 wrap16");
      check("R2 wrap16 value", {12'd0, phys_addr}, 32'h30001);

      // R3 short displacement sign extension
      reg_bx = 16'h0100; set_op(2'd1, 2'd0, 2'd1, 16'h1280);
      issue("R3 short negative");
      check("R3 short negative value", {12'd0, phys_addr}, 32'h30080);
      set_op(2'd1, 2'd0, 2'd1, 16'hAB7F); issue("R3 short positive");
      check("R3 short positive value", {12'd0, phys_addr}, 32'h3017F);

      // R4 BP base defaults to SS, BX base to DS
      seg_ss = 16'h2000; reg_bp = 16'hF000; set_op(2'd2, 2'd0, 2'd0, 16'h0);
      issue("R4 bp");
      check("R4 bp value", {12'd0, phys_addr}, 32'h2F000);
      reg_si = 16'h000E; set_op(2'd2, 2'd1, 2'd1, 16'h0010); issue("R4 bp+si+d8");
      set_op(2'd0, 2'd1, 2'd0, 16'h0); issue("R4 si only");
      check("R4 si value", {12'd0, phys_addr}, 32'h3000E);

      // R5 every override code
      for (int c = 0; c < 6; c++) begin
         set_op(2'd2, 2'd0, 2'd2, 16'h0044);
         ovr_en = 1'b1; ovr_seg = c[2:0];
         issue("R5 override");
      end
      ovr_en = 0;

      // R6 illegal encodings, R9 hold on error
      set_op(2'd0, 2'd0, 2'd2, 16'h0123); issue("R9 setup");
      set_op(2'd3, 2'd0, 2'd2, 16'h0); issue("R6 bad base");
      check("R9 hold after err", {12'd0, phys_addr}, 32'h30123);
      set_op(2'd1, 2'd3, 2'd0, 16'h0); issue("R6 bad index");
      set_op(2'd1, 2'd0, 2'd3, 16'h0); issue("R6 bad disp");
      set_op(2'd0, 2'd0, 2'd0, 16'h0); issue("R6 empty form");
      set_op(2'd1, 2'd0, 2'd0, 16'h0); ovr_en = 1; ovr_seg = 3'd6; issue("R6 ovr 6");
      ovr_seg = 3'd7; issue("R6 ovr 7");
      ovr_en = 0;

      // R7 flags drop and R9 address holds on idle cycles
      @(negedge clk);
      check("R7 idle valid", {31'd0, out_valid}, 32'd0);
      check("R7 idle err",   {31'd0, out_err},   32'd0);
      check("R9 idle hold",  {12'd0, phys_addr}, {12'd0, last_pa});

      // random mix
      for (int i = 0; i < 400; i++) begin
         seg_cs = 16'($urandom); seg_ss = 16'($urandom); seg_ds = 16'($urandom);
         seg_es = 16'($urandom); seg_fs = 16'($urandom); seg_gs = 16'($urandom);
         reg_bx = 16'($urandom); reg_bp = 16'($urandom);
         reg_si = 16'($urandom); reg_di = 16'($urandom);
         base_sel  = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
         index_sel = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
         disp_sel  = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
         disp = 16'($urandom);
         ovr_en = 1'($urandom_range(0, 1));
         ovr_seg = 3'($urandom_range(0, 7));
         issue("R1 R2 R3 R4 R5 R6 random");
      end

      // R8 reset after activity
      set_op(2'd1, 2'd0, 2'd0, 16'h0); ovr_en = 0;
      in_valid = 1; rst = 1;
      @(posedge clk); @(negedge clk);
      rst = 0; in_valid = 0;
      check("R8 late reset addr",  {12'd0, phys_addr}, 32'd0);
      check("R8 late reset valid", {31'd0, out_valid}, 32'd0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule